// File: doc/BRIEF.md
# Scalar FP64 Multiply Result Merger

This block builds the full destination vector register value for a scalar double-precision multiply. It serves three instruction encoding forms: legacy, VEX and EVEX. The floating-point multiplier sits outside the block. The merger gives that multiplier the rounding mode to use. It then takes back the 64-bit product and its exception flags, and combines them with the old destination contents and the first-source vector.

The encoding form decides three things. It sets how the upper lanes are filled. It decides whether a writemask can suppress the low-lane write. It also decides whether an embedded rounding override may replace the global rounding field. Masked-off low lanes are either merged with the old value or cleared, and their exception flags are not reported. Two encodings are refused and flagged: a VEX request with its vector-length bit set, and the reserved form code. The result is registered one clock after a valid request.

Top module: `fp64_mul_wb_merge`

## Requirements
- R1: `rm_out` is combinational and follows the inputs in the same cycle. It equals `embed_rc` only when `enc_form` is EVEX (2'b10), `embed_round_en` is 1 and `src2_is_reg` is 1. In every other case it equals `global_rc`. Codes: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R2: Bits 63:0 of the result are `prod` for every accepted legacy (2'b00) or VEX (2'b01) request, whatever the mask inputs are. They are also `prod` for an EVEX request with `mask_en`=0 or `mask_bit0`=1.
- R3: For an EVEX request with `mask_en`=1, `mask_bit0`=0 and `zero_mask`=0, bits 63:0 keep `old_dest[63:0]`.
- R4: For an EVEX request with `mask_en`=1, `mask_bit0`=0 and `zero_mask`=1, bits 63:0 are zero.
- R5: For accepted VEX and EVEX requests, bits 127:64 of the result are `src1[127:64]`.
- R6: For accepted VEX and EVEX requests, bits VLEN-1:128 of the result are zero.
- R7: For legacy requests, bits VLEN-1:64 of the result are `old_dest[VLEN-1:64]`.
- R8: When the low lane takes the product, `out_flags` equals `prod_flags`. Bit order: [0] invalid, [1] denormal, [2] overflow, [3] underflow, [4] precision.
- R9: When the low lane is masked off (merged or zeroed), `out_flags` is zero.
- R10: A VEX request with `vex_len_bit`=1, or any request with `enc_form`=2'b11, sets `out_bad_enc` to 1. It returns `old_dest` unchanged and zero flags. Accepted requests set `out_bad_enc` to 0.
- R11: `out_valid` is `in_valid` delayed by one clock. `out_dest`, `out_flags` and `out_bad_enc` change only on a cycle after a valid request and otherwise hold. Synchronous reset clears all four outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| enc_form | input | 2 | Encoding form: 00 legacy, 01 VEX, 10 EVEX, 11 reserved |
| vex_len_bit | input | 1 | Vector-length bit of a VEX request (must be 0) |
| mask_en | input | 1 | EVEX writemask in use |
| mask_bit0 | input | 1 | Writemask bit for the low lane |
| zero_mask | input | 1 | 1 = zeroing-masking, 0 = merging-masking |
| embed_round_en | input | 1 | EVEX broadcast/round control bit |
| src2_is_reg | input | 1 | Second source is a register (not memory) |
| embed_rc | input | 2 | Embedded rounding override |
| global_rc | input | 2 | Rounding field of the global control register |
| old_dest | input | VLEN | Previous destination register contents |
| src1 | input | VLEN | First-source vector |
| prod | input | 64 | Product from the multiplier |
| prod_flags | input | 5 | Exception flags from the multiplier |
| rm_out | output | 2 | Rounding mode sent to the multiplier |
| out_valid | output | 1 | Result valid |
| out_dest | output | VLEN | Merged destination value |
| out_flags | output | 5 | Exception flags to report |
| out_bad_enc | output | 1 | Unsupported encoding seen |

## Verification
The rounding mode is combinational, so the bench checks it one time unit after it drives the inputs on a falling edge. That is before any clock edge can intervene. Every other result passes through one register. The bench therefore samples `out_valid`, the lanes, the flags and the encoding error at the next falling edge, which is exactly one rising edge after the request. Idle cycles are checked at the following falling edge to confirm that the outputs hold and that `out_valid` drops.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'b00,
    FORM_VEX    = 2'b01,
    FORM_EVEX   = 2'b10,
    FORM_RSVD   = 2'b11
  } form_e;

  localparam int LANE_W = 64;
  localparam int FLAG_W = 5;

  // exception flag positions
  localparam int FLG_INVALID   = 0;
  localparam int FLG_DENORMAL  = 1;
  localparam int FLG_OVERFLOW  = 2;
  localparam int FLG_UNDERFLOW = 3;
  localparam int FLG_PRECISION = 4;

  typedef logic [1:0] rmode_t;
  localparam rmode_t RM_NEAR_EVEN = 2'b00;
  localparam rmode_t RM_DOWN      = 2'b01;
  localparam rmode_t RM_UP        = 2'b10;
  localparam rmode_t RM_TRUNC     = 2'b11;

endpackage

// File: rtl/wbm_round_pick.sv
module wbm_round_pick
  import wbm_pkg::*;
(
  input  form_e  form,
  input  logic   embed_en,
  input  logic   src2_reg,
  input  rmode_t embed_rc,
  input  rmode_t global_rc,
  output rmode_t rm
);

  logic use_embed;

  always_comb begin
    use_embed = (form == FORM_EVEX) && embed_en && src2_reg;
    rm        = use_embed ? embed_rc : global_rc;
  end

endmodule

// File: rtl/wbm_low_lane.sv
module wbm_low_lane
  import wbm_pkg::*;
(
  input  form_e              form,
  input  logic               mask_en,
  input  logic               mask_b0,
  input  logic               zero_mode,
  input  logic [LANE_W-1:0]  old_low,
  input  logic [LANE_W-1:0]  prod,
  input  logic [FLAG_W-1:0]  prod_flags,
  output logic [LANE_W-1:0]  low_out,
  output logic [FLAG_W-1:0]  flags_out
);

  logic lane_write;

  always_comb begin
    // only the EVEX form honours a writemask
    lane_write = (form != FORM_EVEX) || !mask_en || mask_b0;
    if (lane_write)
      low_out = prod;
    else if (zero_mode)
      low_out = '0;
    else
      low_out = old_low;
    flags_out = lane_write ? prod_flags : '0;
  end

endmodule

// File: rtl/wbm_upper_lanes.sv
module wbm_upper_lanes
  import wbm_pkg::*;
#(
  parameter int VLEN = 512
)(
  input  form_e             form,
  input  logic [VLEN-1:0]   old_dest,
  input  logic [VLEN-1:0]   src1,
  output logic [VLEN-1:LANE_W] upper_out
);

  localparam int LANES = VLEN / LANE_W;

  logic keep_old;
  assign keep_old = (form == FORM_LEGACY);

  // lane 1 comes from the first source in the newer forms
  assign upper_out[2*LANE_W-1:LANE_W] = keep_old ? old_dest[2*LANE_W-1:LANE_W]
                                                 : src1[2*LANE_W-1:LANE_W];

  // lanes 2 and up are either preserved or cleared
  for (genvar g = 2; g < LANES; g++) begin : g_hi_lane
    assign upper_out[g*LANE_W +: LANE_W] = keep_old ? old_dest[g*LANE_W +: LANE_W]
                                                    : '0;
  end

endmodule

// File: rtl/fp64_mul_wb_merge.sv
module fp64_mul_wb_merge
  import wbm_pkg::*;
#(
  parameter int VLEN = 512
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        enc_form,
  input  logic              vex_len_bit,
  input  logic              mask_en,
  input  logic              mask_bit0,
  input  logic              zero_mask,
  input  logic              embed_round_en,
  input  logic              src2_is_reg,
  input  logic [1:0]        embed_rc,
  input  logic [1:0]        global_rc,
  input  logic [VLEN-1:0]   old_dest,
  input  logic [VLEN-1:0]   src1,
  input  logic [63:0]       prod,
  input  logic [4:0]        prod_flags,
  output logic [1:0]        rm_out,
  output logic              out_valid,
  output logic [VLEN-1:0]   out_dest,
  output logic [4:0]        out_flags,
  output logic              out_bad_enc
);

  localparam int LANES = VLEN / LANE_W;

  form_e form;
  assign form = form_e'(enc_form);

  // rounding mode to the multiplier
  wbm_round_pick u_round (
    .form      (form),
    .embed_en  (embed_round_en),
    .src2_reg  (src2_is_reg),
    .embed_rc  (embed_rc),
    .global_rc (global_rc),
    .rm        (rm_out)
  );

  // R1
  rm_global_chk: assert property (@(posedge clk) disable iff (rst)
    (enc_form != 2'b10) |-> (rm_out == global_rc))
    else $error("rounding override leaked outside EVEX form");

  logic [LANE_W-1:0] low_val;
  logic [FLAG_W-1:0] low_flags;

  wbm_low_lane u_low (
    .form       (form),
    .mask_en    (mask_en),
    .mask_b0    (mask_bit0),
    .zero_mode  (zero_mask),
    .old_low    (old_dest[LANE_W-1:0]),
    .prod       (prod),
    .prod_flags (prod_flags),
    .low_out    (low_val),
    .flags_out  (low_flags)
  );

  logic [VLEN-1:LANE_W] upper_val;

  wbm_upper_lanes #(.VLEN(VLEN)) u_upper (
    .form      (form),
    .old_dest  (old_dest),
    .src1      (src1),
    .upper_out (upper_val)
  );

  logic            bad_enc;
  logic [VLEN-1:0] next_dest;
  logic [4:0]      next_flags;

  always_comb begin
    bad_enc    = (form == FORM_RSVD) || ((form == FORM_VEX) && vex_len_bit);
    next_dest  = bad_enc ? old_dest : {upper_val, low_val};
    next_flags = bad_enc ? '0 : low_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_dest    <= '0;
      out_flags   <= '0;
      out_bad_enc <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dest    <= next_dest;
        out_flags   <= next_flags;
        out_bad_enc <= bad_enc;
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid not propagated");

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("spurious valid");

  // R11
  hold_dest_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_dest)) else $error("destination changed while idle");

  // R10
  bad_vex_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_form == 2'b01 && vex_len_bit) |=> (out_bad_enc && out_flags == '0))
    else $error("VEX length bit not refused");

  // R9
  masked_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_form == 2'b10 && mask_en && !mask_bit0) |=> (out_flags == '0))
    else $error("flags reported for masked lane");

  // R4
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_form == 2'b10 && mask_en && !mask_bit0 && zero_mask)
      |=> (out_dest[LANE_W-1:0] == '0))
    else $error("zeroing mask left low lane nonzero");

  // R7
  legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_form == 2'b00) |=> (out_dest[VLEN-1:LANE_W] == $past(old_dest[VLEN-1:LANE_W])))
    else $error("legacy upper lanes not preserved");

  if (LANES > 2) begin : g_clear_chk
    // R6
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (enc_form == 2'b10 || (enc_form == 2'b01 && !vex_len_bit)))
        |=> (out_dest[VLEN-1:2*LANE_W] == '0))
      else $error("upper lanes not cleared");
  end

endmodule

// File: tb/fp64_mul_wb_merge_test.sv
module fp64_mul_wb_merge_test;

  localparam int VLEN = 512;
  localparam int LW   = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic            in_valid;
  logic [1:0]      enc_form;
  logic            vex_len_bit, mask_en, mask_bit0, zero_mask, embed_round_en, src2_is_reg;
  logic [1:0]      embed_rc, global_rc;
  logic [VLEN-1:0] old_dest, src1;
  logic [63:0]     prod;
  logic [4:0]      prod_flags;
  logic [1:0]      rm_out;
  logic            out_valid;
  logic [VLEN-1:0] out_dest;
  logic [4:0]      out_flags;
  logic            out_bad_enc;

  fp64_mul_wb_merge #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_form(enc_form),
    .vex_len_bit(vex_len_bit), .mask_en(mask_en), .mask_bit0(mask_bit0),
    .zero_mask(zero_mask), .embed_round_en(embed_round_en), .src2_is_reg(src2_is_reg),
    .embed_rc(embed_rc), .global_rc(global_rc), .old_dest(old_dest), .src1(src1),
    .prod(prod), .prod_flags(prod_flags), .rm_out(rm_out), .out_valid(out_valid),
    .out_dest(out_dest), .out_flags(out_flags), .out_bad_enc(out_bad_enc)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic is_bad(input logic [1:0] f, input logic lb);
    return (f == 2'b11) || (f == 2'b01 && lb);
  endfunction

  function automatic logic low_writes(input logic [1:0] f, input logic me, input logic mb);
    return (f != 2'b10) || !me || mb;
  endfunction

  function automatic logic [VLEN-1:0] model_dest(
      input logic [1:0] f, input logic lb, input logic [VLEN-1:0] od,
      input logic [VLEN-1:0] s1, input logic me, input logic mb, input logic zm,
      input logic [63:0] p);
    logic [VLEN-1:0] d;
    if (is_bad(f, lb)) return od;
    d = '0;
    if (f == 2'b00) d = od;
    else d[2*LW-1:LW] = s1[2*LW-1:LW];
    if (low_writes(f, me, mb)) d[LW-1:0] = p;
    else if (zm) d[LW-1:0] = '0;
    else d[LW-1:0] = od[LW-1:0];
    return d;
  endfunction

  function automatic logic [1:0] model_rm(input logic [1:0] f, input logic re,
                                          input logic sr, input logic [1:0] erc,
                                          input logic [1:0] grc);
    return (f == 2'b10 && re && sr) ? erc : grc;
  endfunction

  // called right after a falling edge; returns right after the next one
  task automatic run_op(input logic [1:0] f, input logic lb, input logic me,
                        input logic mb, input logic zm, input logic re,
                        input logic sr, input logic [1:0] erc, input logic [1:0] grc);
    logic [VLEN-1:0] exp_d;
    logic [4:0]      exp_f;
    string           low_tag;
    in_valid = 1'b1; enc_form = f; vex_len_bit = lb; mask_en = me; mask_bit0 = mb;
    zero_mask = zm; embed_round_en = re; src2_is_reg = sr; embed_rc = erc; global_rc = grc;
    old_dest = rand_vec(); src1 = rand_vec();
    prod = {$urandom(), $urandom()}; prod_flags = 5'($urandom());
    exp_d = model_dest(f, lb, old_dest, src1, me, mb, zm, prod);
    exp_f = (is_bad(f, lb) || !low_writes(f, me, mb)) ? 5'd0 : prod_flags;
    #1;
    // R1
    chk("R1", "rm_out", VLEN'(rm_out), VLEN'(model_rm(f, re, sr, erc, grc)));
    @(posedge clk);
    @(negedge clk);
    chk("R11", "out_valid", VLEN'(out_valid), VLEN'(1'b1));
    if (is_bad(f, lb)) begin
      // R10
      chk("R10", "out_bad_enc", VLEN'(out_bad_enc), VLEN'(1'b1));
      chk("R10", "dest", out_dest, exp_d);
      chk("R10", "flags", VLEN'(out_flags), VLEN'(exp_f));
    end else begin
      chk("R10", "out_bad_enc", VLEN'(out_bad_enc), VLEN'(1'b0));
      if (low_writes(f, me, mb)) low_tag = "R2";
      else if (zm) low_tag = "R4";
      else low_tag = "R3";
      chk(low_tag, "low lane", VLEN'(out_dest[LW-1:0]), VLEN'(exp_d[LW-1:0]));
      chk((f == 2'b00) ? "R7" : "R5", "lane 1",
          VLEN'(out_dest[2*LW-1:LW]), VLEN'(exp_d[2*LW-1:LW]));
      chk((f == 2'b00) ? "R7" : "R6", "upper lanes",
          VLEN'(out_dest[VLEN-1:2*LW]), VLEN'(exp_d[VLEN-1:2*LW]));
      chk(low_writes(f, me, mb) ? "R8" : "R9", "flags", VLEN'(out_flags), VLEN'(exp_f));
    end
  endtask

  task automatic idle_check();
    logic [VLEN-1:0] held_d;
    logic [4:0]      held_f;
    held_d = out_dest; held_f = out_flags;
    in_valid = 1'b0;
    old_dest = rand_vec(); prod = {$urandom(), $urandom()}; prod_flags = 5'h1f;
    @(posedge clk);
    @(negedge clk);
    // R11
    chk("R11", "idle out_valid", VLEN'(out_valid), VLEN'(1'b0));
    chk("R11", "idle hold dest", out_dest, held_d);
    chk("R11", "idle hold flags", VLEN'(out_flags), VLEN'(held_f));
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; in_valid = 1'b0; enc_form = 2'b00; vex_len_bit = 1'b0;
    mask_en = 1'b0; mask_bit0 = 1'b0; zero_mask = 1'b0; embed_round_en = 1'b0;
    src2_is_reg = 1'b0; embed_rc = 2'b00; global_rc = 2'b00;
    old_dest = '0; src1 = '0; prod = '0; prod_flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11", "reset out_valid", VLEN'(out_valid), VLEN'(1'b0));
    chk("R11", "reset out_dest", out_dest, '0);
    chk("R11", "reset out_flags", VLEN'(out_flags), '0);
    chk("R11", "reset out_bad_enc", VLEN'(out_bad_enc), '0);

    // directed corners
    run_op(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b01); // R7: legacy ignores mask
    run_op(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00); // R5 R6 VEX
    run_op(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 2'b10); // R3 merge
    run_op(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00); // R4 zero
    run_op(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 2'b01); // R1 memory source
    run_op(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 2'b11); // R2 no mask
    run_op(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10); // R10 length bit
    run_op(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00); // R10 reserved
    idle_check();

    for (int n = 0; n < 400; n++) begin
      run_op(2'($urandom_range(3, 0)), 1'($urandom_range(3, 0) == 0), 1'($urandom()),
             1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
             2'($urandom()), 2'($urandom()));
      if ((n % 37) == 0) idle_check();
    end
    idle_check();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule